// File: doc/BRIEF.md
# Interleaved Block Refill Controller

This controller fills one cache line after a miss. It accepts a block address from the cache side and sends it to four memory banks in a single address cycle. All four banks begin their access together. Bank k holds word k of the block.

Each bank delivers its word after a fixed access time. The controller keeps the four words and sends them back in ascending order over a bus one word wide, one word per cycle. Each word carries its index and a valid strobe. A one-cycle done pulse comes with the last word.

With an access time of 15 cycles, the miss penalty is 1 + 15 + 4 = 20 cycles. A cycle counter makes the refill latency visible at the ports.

Top module: `refill_ctrl`

## Requirements
- R1: While rst_ni is low, busy_o, mem_addr_valid_o, word_valid_o and done_o are low and lat_cnt_o is 0. This also holds when reset is applied in the middle of a refill.
- R2: In the idle state, a high req_valid_i at a clock edge is accepted. mem_addr_valid_o is then high for exactly the next cycle, with mem_addr_o equal to the accepted req_addr_i.
- R3: The word sent with word_idx_o = k equals the slice bank_rdata_i[k*32 +: 32] captured from bank k.
- R4: Words leave in consecutive cycles with word_idx_o taking the values 0, 1, 2 and 3.
- R5: The first word appears in the cycle after all banks have returned data. With a 15-cycle bank access, the address cycle is cycle 1 and the words appear in cycles 17 to 20.
- R6: done_o is high for exactly one cycle, in the same cycle as the word with index 3.
- R7: busy_o is high from the address cycle through the done cycle and low in the following cycle.
- R8: req_valid_i and req_addr_i are ignored while busy_o is high: no second address cycle occurs and mem_addr_o does not change.
- R9: lat_cnt_o is 1 in the address cycle and increases by one each cycle. It equals 1 + access time + 4 (20) in the done cycle, and it holds that value while idle until the next request is accepted.
- R10: bank_rvalid_i is ignored unless the controller is waiting for bank data. A stray strobe while idle produces no word and does not set busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request strobe |
| req_addr_i | input | BLK_ADDR_W | Block address of the missing line |
| busy_o | output | 1 | Refill in progress |
| mem_addr_valid_o | output | 1 | Address cycle, starts all banks |
| mem_addr_o | output | BLK_ADDR_W | Block address sent to every bank |
| bank_rvalid_i | input | NWORDS | Per-bank data-return strobe |
| bank_rdata_i | input | NWORDS*WORD_W | Bank k data in slice k |
| word_valid_o | output | 1 | Word strobe on the narrow bus |
| word_idx_o | output | IDX_W | Index of the word in the block |
| word_o | output | WORD_W | Word data |
| done_o | output | 1 | Pulse with the last word |
| lat_cnt_o | output | CNT_W | Cycles since the address cycle |

## Verification
The bench builds the controller with four 32-bit words and a 15-cycle access time, so the 20-cycle penalty can be checked cycle by cycle. The block address is narrowed to 8 bits, so random addresses often hit all-zero, all-one and repeated values. Random requests mix back-to-back refills and requests raised while busy. Directed cases cover a stray bank strobe while idle and a reset in the middle of a refill followed by late bank data.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_XFER = 2'd3
  } refill_state_e;
endpackage

// File: rtl/refill_fsm.sv
module refill_fsm
  import refill_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int IDX_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             all_arrived_i,
  output refill_state_e    state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  refill_state_e state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) state_q <= ST_ADDR;
        ST_ADDR: state_q <= ST_WAIT;
        ST_WAIT: if (all_arrived_i) begin
          state_q <= ST_XFER;
          idx_q   <= '0;
        end
        ST_XFER: begin
          if (idx_q == LAST_IDX) state_q <= ST_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign done_o  = (state_q == ST_XFER) && (idx_q == LAST_IDX);

  // R5: the transfer starts only once every bank has returned data
  assert_xfer_after_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !all_arrived_i) |=> state_q == ST_WAIT);
endmodule

// File: rtl/refill_bank_buf.sv
module refill_bank_buf #(
  parameter int NWORDS = 4,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     capture_en_i,
  input  logic [NWORDS-1:0]        bank_rvalid_i,
  input  logic [NWORDS*WORD_W-1:0] bank_rdata_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic                     all_arrived_o,
  output logic [WORD_W-1:0]        rd_word_o
);
  logic [NWORDS-1:0] got_q;
  logic [NWORDS-1:0] arriving;
  logic [WORD_W-1:0] word_q [NWORDS];

  for (genvar k = 0; k < NWORDS; k++) begin : g_bank
    assign arriving[k] = capture_en_i & bank_rvalid_i[k] & ~got_q[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        got_q[k]  <= 1'b0;
        word_q[k] <= '0;
      end else if (clear_i) begin
        got_q[k]  <= 1'b0;
      end else if (arriving[k]) begin
        got_q[k]  <= 1'b1;
        word_q[k] <= bank_rdata_i[k*WORD_W +: WORD_W];
      end
    end
  end

  assign all_arrived_o = capture_en_i & (&(got_q | bank_rvalid_i));
  assign rd_word_o     = word_q[rd_idx_i];

  // R10: nothing is captured outside the wait window
  assert_no_stray_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_en_i && !clear_i) |=> $stable(got_q));
endmodule

// File: rtl/refill_lat_cnt.sv
module refill_lat_cnt #(
  parameter int TOTAL = 20,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(1);
    else if (run_i && !stop_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R9: the refill completes exactly TOTAL cycles after the address cycle
  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> cnt_q == CNT_W'(TOTAL));
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int NWORDS     = 4,
  parameter int WORD_W     = 32,
  parameter int BLK_ADDR_W = 26,
  parameter int ACCESS_LAT = 15,
  localparam int IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int TOTAL     = 1 + ACCESS_LAT + NWORDS,
  localparam int CNT_W     = $clog2(TOTAL + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [BLK_ADDR_W-1:0]    req_addr_i,
  output logic                     busy_o,
  output logic                     mem_addr_valid_o,
  output logic [BLK_ADDR_W-1:0]    mem_addr_o,
  input  logic [NWORDS-1:0]        bank_rvalid_i,
  input  logic [NWORDS*WORD_W-1:0] bank_rdata_i,
  output logic                     word_valid_o,
  output logic [IDX_W-1:0]         word_idx_o,
  output logic [WORD_W-1:0]        word_o,
  output logic                     done_o
  ,output logic [CNT_W-1:0]        lat_cnt_o
);
  refill_state_e state;
  logic [IDX_W-1:0] idx;
  logic all_arrived, accept, done;
  logic [BLK_ADDR_W-1:0] addr_q;

  assign accept = (state == ST_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (accept) addr_q <= req_addr_i;
  end

  refill_fsm #(.NWORDS(NWORDS), .IDX_W(IDX_W)) i_fsm (
    .clk_i, .rst_ni,
    .req_valid_i,
    .all_arrived_i(all_arrived),
    .state_o(state),
    .idx_o(idx),
    .done_o(done)
  );

  refill_bank_buf #(.NWORDS(NWORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)) i_buf (
    .clk_i, .rst_ni,
    .clear_i(state == ST_ADDR),
    .capture_en_i(state == ST_WAIT),
    .bank_rvalid_i,
    .bank_rdata_i,
    .rd_idx_i(idx),
    .all_arrived_o(all_arrived),
    .rd_word_o(word_o)
  );

  refill_lat_cnt #(.TOTAL(TOTAL), .CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .start_i(accept),
    .run_i(state != ST_IDLE),
    .stop_i(done),
    .cnt_o(lat_cnt_o)
  );

  assign busy_o           = (state != ST_IDLE);
  assign mem_addr_valid_o = (state == ST_ADDR);
  assign mem_addr_o       = addr_q;
  assign word_valid_o     = (state == ST_XFER);
  assign word_idx_o       = idx;
  assign done_o           = done;

  assert_addr_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_addr_valid_o |=> !mem_addr_valid_o);
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> mem_addr_valid_o && mem_addr_o == $past(req_addr_i));
  assert_ignore_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(mem_addr_o) && busy_o);
  assert_first_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) |-> word_idx_o == '0);
  assert_word_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !done_o) |=> word_valid_o && word_idx_o == IDX_W'($past(word_idx_o) + 1'b1));
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !word_valid_o);
  assert_busy_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: tb/test_refill_ctrl.sv
module test_refill_ctrl;
  localparam int NW = 4;
  localparam int WW = 32;
  localparam int AW = 8;
  localparam int LAT = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic busy, addr_valid, word_valid, done;
  logic [AW-1:0] mem_addr;
  logic [NW-1:0] bank_rvalid = '0;
  logic [NW*WW-1:0] bank_rdata = '0;
  logic [1:0] word_idx;
  logic [WW-1:0] word;
  logic [4:0] lat_cnt;

  logic [WW-1:0] bank_word [NW];
  int stray_req = 0;
  int n_chk = 0, n_fail = 0;

  always #10ns clk = ~clk;

  refill_ctrl #(.NWORDS(NW), .WORD_W(WW), .BLK_ADDR_W(AW), .ACCESS_LAT(LAT)) i_refill_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .busy_o(busy), .mem_addr_valid_o(addr_valid), .mem_addr_o(mem_addr),
    .bank_rvalid_i(bank_rvalid), .bank_rdata_i(bank_rdata),
    .word_valid_o(word_valid), .word_idx_o(word_idx), .word_o(word),
    .done_o(done), .lat_cnt_o(lat_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NW*WW-1:0] pack_words();
    logic [NW*WW-1:0] v;
    for (int k = 0; k < NW; k++) v[k*WW +: WW] = bank_word[k];
    return v;
  endfunction

  // fixed-latency bank responders, all banks started by one address cycle
  initial begin
    int stray_seen;
    stray_seen = 0;
    forever begin
      @(negedge clk);
      if (addr_valid) begin
        repeat (LAT) @(negedge clk);
        bank_rdata  = pack_words();
        bank_rvalid = '1;
        @(negedge clk);
        bank_rvalid = '0;
      end else if (stray_req != stray_seen) begin
        stray_seen  = stray_req;
        bank_rdata  = '1;
        bank_rvalid = '1;
        repeat (2) @(negedge clk);
        bank_rvalid = '0;
      end
    end
  end

  // one full refill; poke raises a conflicting request while busy
  task automatic run_refill(input logic [AW-1:0] a, input bit poke);
    bit bad;
    logic [63:0] bad_v;
    for (int k = 0; k < NW; k++) bank_word[k] = $urandom;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);  // cycle 1
    req_valid = poke;
    req_addr  = ~a;
    chk(addr_valid && mem_addr == a && busy && lat_cnt == 5'd1,
        "R2 address cycle", {addr_valid, busy, lat_cnt, mem_addr}, {1'b1, 1'b1, 5'd1, a});
    chk(lat_cnt == 5'd1, "R9 count in address cycle", lat_cnt, 1);
    bad = 0; bad_v = 0;
    for (int c = 2; c <= 16; c++) begin
      @(negedge clk);
      if (c == 10) req_valid = 1'b0;
      if (addr_valid || word_valid || !busy || mem_addr != a || lat_cnt != 5'(c)) begin
        bad = 1; bad_v = {addr_valid, word_valid, busy, mem_addr, lat_cnt};
      end
    end
    chk(!bad, poke ? "R8 request while busy ignored" : "R7 busy during access", bad_v, {3'b001, a, 5'd16});
    for (int k = 0; k < NW; k++) begin
      @(negedge clk);  // cycles 17..20
      chk(word_valid && word_idx == 2'(k), "R4 word order", {word_valid, word_idx}, {1'b1, 2'(k)});
      chk(word == bank_word[k], "R3 word from bank k", word, bank_word[k]);
      chk(done == (k == NW - 1), "R6 done with last word", done, (k == NW - 1));
      chk(lat_cnt == 5'(17 + k), "R5 word timing", lat_cnt, 17 + k);
    end
    @(negedge clk);  // cycle 21
    chk(!busy && !done && !word_valid && !addr_valid, "R7 idle after done",
        {busy, done, word_valid, addr_valid}, 0);
    chk(lat_cnt == 5'd20, "R9 count holds at penalty", lat_cnt, 20);
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    chk(!busy && !addr_valid && !word_valid && !done && lat_cnt == 0, "R1 reset state",
        {busy, addr_valid, word_valid, done, lat_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_refill(8'h00, 0);
    run_refill(8'hFF, 1);
    run_refill(8'hFF, 0);  // back to back, same address

    // R10: stray bank strobe while idle
    stray_req++;
    begin
      bit bad;
      bad = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (word_valid || busy || done || lat_cnt != 5'd20) bad = 1;
      end
      chk(!bad, "R10 stray strobe ignored", {word_valid, busy, lat_cnt}, 20);
    end

    // R1: reset in the middle of a refill, late bank data ignored (R10)
    req_valid = 1'b1; req_addr = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !addr_valid && !word_valid && lat_cnt == 0, "R1 reset mid refill",
        {busy, addr_valid, word_valid, lat_cnt}, 0);
    rst_n = 1'b1;
    begin
      bit bad;
      bad = 0;
      for (int c = 0; c < 14; c++) begin
        @(negedge clk);
        if (word_valid || busy || done) bad = 1;
      end
      chk(!bad, "R10 late bank data after reset ignored", {word_valid, busy, done}, 0);
    end

    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if (i % 7 == 3) a = '1;
      run_refill(a, ($urandom % 3) == 0);
      if ($urandom % 2) repeat ($urandom % 4) @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule